// File: doc/BRIEF.md
# Multiplexed Boot ROM Read Sequencer

This block fetches a byte or a 32-bit word from an external boot ROM of up to 256 KB. The ROM sits behind a narrow bus. One 8-bit output bus carries two slices of the address in turn, and the ROM answers on an 8-bit input bus. Two dedicated pins carry the lowest two address bits. In the first phase the bus carries the top eight address bits, and a strobe lets an external latch capture them. In the second phase the bus carries the next eight bits under a second strobe. The block then releases the bus, pulls the active-low chip enable low, and reads data one byte at a time. In word mode the two low pins step through four byte fetches.

A host launches a read with a one-cycle control write. The write must carry both the read-control bit and the ROM-select bit, plus the mode and the 18-bit address. The block samples the phase length at launch. Every phase lasts that many clocks, and the ROM byte is sampled on the last clock of each data phase. The assembled result leaves through a valid/ready response port. The result stays on that port until the host accepts it.

Back-pressure works as follows. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold. The transfer happens on a clock edge where both are high. The block accepts no new launch until the pending response has been taken.

Top module: `bootrom_rd_seq`

## Requirements
- R1: After reset `busy` and `rsp_valid` are 0, `rom_ce_n` is 1, and `rom_ad_oe`, `rom_hi_le` and `rom_mid_le` are 0. `rom_ad_o` and `rom_a` read 0 whenever they are not being driven for a phase.
- R2: A launch is accepted only on a clock where `ctl_wr`, `ctl_rd` and `ctl_sel` are all 1. A write that lacks either bit leaves `busy` at 0.
- R3: A launch attempt is ignored while `busy` is 1 or while `rsp_valid` is 1. It does not change the response data of the access already running or pending.
- R4: First phase: `rom_ad_oe`=1, `rom_hi_le`=1, and `rom_ad_o` carries address bits 17:10.
- R5: Second phase: `rom_ad_oe`=1, `rom_mid_le`=1, and `rom_ad_o` carries address bits 9:2.
- R6: Byte mode (`ctl_word`=0) has one data phase with `rom_ce_n`=0, `rom_ad_oe`=0 and `rom_a` = address bits 1:0. The sampled byte is returned in bits 7:0, and bits 31:8 are 0.
- R7: Word mode (`ctl_word`=1) has four data phases with `rom_a` = 0, 1, 2, 3 in that order. Address bits 1:0 are ignored. The byte read with `rom_a`=i lands in bits 8i+7:8i.
- R8: `cfg_phase` values 1 to 15 give that many clocks per phase, and 0 gives 4. `busy` stays high for exactly (2+k)·N clocks, where k is 1 in byte mode and 4 in word mode.
- R9: `busy` falls on the same edge where `rsp_valid` rises. While `rsp_valid`=1 and `rsp_ready`=0, both `rsp_valid` and `rsp_data` hold. `rsp_valid` clears after an edge where `rsp_ready`=1.
- R10: At most one of `rom_hi_le`, `rom_mid_le` and the active chip enable is asserted at a time. The bus output is never enabled while the chip enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe, one cycle |
| ctl_rd | input | 1 | Read-control bit of the write |
| ctl_sel | input | 1 | ROM-select bit of the write |
| ctl_word | input | 1 | 1 = 32-bit word read, 0 = byte read |
| ctl_addr | input | 18 | ROM byte address |
| cfg_phase | input | 4 | Clocks per phase, 0 selects 4 |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | Response data valid |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_data | output | 32 | Assembled read data |
| rom_ad_o | output | 8 | Multiplexed address bus out |
| rom_ad_oe | output | 1 | Bus output enable |
| rom_ad_i | input | 8 | ROM data in |
| rom_a | output | 2 | Dedicated low address pins |
| rom_ce_n | output | 1 | Active-low ROM chip enable |
| rom_hi_le | output | 1 | Strobe for the high-address latch |
| rom_mid_le | output | 1 | Strobe for the middle-address latch |

## Verification
The assertions take for granted that the host holds `rsp_ready` and the control inputs steady between clock edges. They also take for granted that `rom_ad_i` is settled by the last clock of each data phase. The bench drives every input on the falling edge. Its ROM model computes each byte combinationally from the latched slices and `rom_a`, so data is stable well before the sampling edge. Launch attempts while busy or while a response is held come from the same falling-edge driver and last exactly one cycle.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int ADDR_W    = 18;
  localparam int BUS_W     = 8;
  localparam int DATA_W    = 32;
  localparam int LANES     = DATA_W / BUS_W;
  localparam int LANE_W    = $clog2(LANES);
  localparam int PH_W      = 4;
  localparam int DEF_PHASE = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_MID  = 2'd2,
    ST_DATA = 2'd3
  } brs_state_e;
endpackage

// File: rtl/brs_phase_timer.sv
module brs_phase_timer #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PH_W-1:0] len_m1,
  output logic            last
);
  logic [PH_W-1:0] cnt;

  assign last = run && (cnt == len_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || last)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/brs_sequencer.sv
module brs_sequencer
  import brs_pkg::*;
#(
  parameter int P_LANES  = LANES,
  parameter int P_LANE_W = LANE_W,
  parameter int P_PH_W   = PH_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                word,
  input  logic [P_PH_W-1:0]   len_m1,
  output brs_state_e          state,
  output logic [P_LANE_W-1:0] lane,
  output logic                sample,
  output logic                done
);
  localparam logic [P_LANE_W-1:0] LAST_LANE = P_LANE_W'(P_LANES - 1);

  logic phase_end;

  brs_phase_timer #(.PH_W(P_PH_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state != ST_IDLE),
    .len_m1 (len_m1),
    .last   (phase_end)
  );

  assign sample = (state == ST_DATA) && phase_end;
  assign done   = sample && (!word || lane == LAST_LANE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      lane  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (launch) begin
          state <= ST_HI;
          lane  <= '0;
        end
        ST_HI:  if (phase_end) state <= ST_MID;
        ST_MID: if (phase_end) state <= ST_DATA;
        ST_DATA: if (phase_end) begin
          if (done) state <= ST_IDLE;
          else      lane  <= lane + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/brs_bus_drive.sv
module brs_bus_drive
  import brs_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_BUS_W  = BUS_W,
  parameter int P_LANE_W = LANE_W
) (
  input  brs_state_e            state,
  input  logic [P_ADDR_W-1:0]   addr,
  input  logic                  word,
  input  logic [P_LANE_W-1:0]   lane,
  output logic [P_BUS_W-1:0]    ad_o,
  output logic                  ad_oe,
  output logic [P_LANE_W-1:0]   a_lo,
  output logic                  ce_n,
  output logic                  hi_le,
  output logic                  mid_le
);
  localparam int HI_LSB  = P_ADDR_W - P_BUS_W;
  localparam int MID_LSB = P_LANE_W;

  always_comb begin
    ad_o   = '0;
    ad_oe  = 1'b0;
    a_lo   = '0;
    ce_n   = 1'b1;
    hi_le  = 1'b0;
    mid_le = 1'b0;
    unique case (state)
      ST_HI: begin
        ad_o  = addr[HI_LSB +: P_BUS_W];
        ad_oe = 1'b1;
        hi_le = 1'b1;
      end
      ST_MID: begin
        ad_o   = addr[MID_LSB +: P_BUS_W];
        ad_oe  = 1'b1;
        mid_le = 1'b1;
      end
      ST_DATA: begin
        ce_n = 1'b0;
        a_lo = word ? lane : addr[P_LANE_W-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/brs_assembler.sv
module brs_assembler #(
  parameter int LANES  = 4,
  parameter int LANE_W = 2,
  parameter int BUS_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   sample,
  input  logic [LANE_W-1:0]      lane,
  input  logic [BUS_W-1:0]       din,
  output logic [LANES*BUS_W-1:0] acc
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   acc[g*BUS_W +: BUS_W] <= '0;
      else if (clear)                               acc[g*BUS_W +: BUS_W] <= '0;
      else if (sample && lane == LANE_W'(g))        acc[g*BUS_W +: BUS_W] <= din;
    end
  end
endmodule

// File: rtl/bootrom_rd_seq.sv
module bootrom_rd_seq
  import brs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic              ctl_sel,
  input  logic              ctl_word,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [PH_W-1:0]   cfg_phase,
  output logic              busy,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [BUS_W-1:0]  rom_ad_o,
  output logic              rom_ad_oe,
  input  logic [BUS_W-1:0]  rom_ad_i,
  output logic [LANE_W-1:0] rom_a,
  output logic              rom_ce_n,
  output logic              rom_hi_le,
  output logic              rom_mid_le
);
  localparam logic [PH_W-1:0] DEF_M1 = PH_W'(DEF_PHASE - 1);

  brs_state_e        state;
  logic [LANE_W-1:0] lane;
  logic              sample, done, launch;
  logic [ADDR_W-1:0] addr_q;
  logic              word_q;
  logic [PH_W-1:0]   len_m1_q;

  assign busy   = (state != ST_IDLE);
  assign launch = ctl_wr && ctl_rd && ctl_sel && !busy && !rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      word_q   <= 1'b0;
      len_m1_q <= DEF_M1;
    end else if (launch) begin
      addr_q   <= ctl_addr;
      word_q   <= ctl_word;
      len_m1_q <= (cfg_phase == '0) ? DEF_M1 : cfg_phase - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rsp_valid <= 1'b0;
    else if (done)                    rsp_valid <= 1'b1;
    else if (rsp_valid && rsp_ready)  rsp_valid <= 1'b0;
  end

  brs_sequencer u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .word   (word_q),
    .len_m1 (len_m1_q),
    .state  (state),
    .lane   (lane),
    .sample (sample),
    .done   (done)
  );

  brs_bus_drive u_drv (
    .state  (state),
    .addr   (addr_q),
    .word   (word_q),
    .lane   (lane),
    .ad_o   (rom_ad_o),
    .ad_oe  (rom_ad_oe),
    .a_lo   (rom_a),
    .ce_n   (rom_ce_n),
    .hi_le  (rom_hi_le),
    .mid_le (rom_mid_le)
  );

  brs_assembler #(.LANES(LANES), .LANE_W(LANE_W), .BUS_W(BUS_W)) u_asm (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (launch),
    .sample (sample),
    .lane   (word_q ? lane : '0),
    .din    (rom_ad_i),
    .acc    (rsp_data)
  );
endmodule

// File: rtl/brs_checker.sv
module brs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic        ctl_rd,
  input logic        ctl_sel,
  input logic        busy,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        rom_ad_oe,
  input logic        rom_ce_n,
  input logic        rom_hi_le,
  input logic        rom_mid_le
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rom_ce_n && !rom_ad_oe && !rom_hi_le && !rom_mid_le));

  assert_launch_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctl_wr && ctl_rd && ctl_sel && !rsp_valid));

  assert_no_launch_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> !busy);

  assert_bus_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ad_oe |-> (rom_hi_le || rom_mid_le));

  assert_end_with_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $rose(rsp_valid));

  assert_hold_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_hi_le, rom_mid_le, !rom_ce_n}));

  assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ad_oe |-> rom_ce_n);
endmodule

bind bootrom_rd_seq brs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_rd     (ctl_rd),
  .ctl_sel    (ctl_sel),
  .busy       (busy),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rom_ad_oe  (rom_ad_oe),
  .rom_ce_n   (rom_ce_n),
  .rom_hi_le  (rom_hi_le),
  .rom_mid_le (rom_mid_le)
);

// File: tb/sim_bootrom_rd_seq.sv
module sim_bootrom_rd_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0, ctl_rd = 1'b0, ctl_sel = 1'b0, ctl_word = 1'b0;
  logic [17:0] ctl_addr = '0;
  logic [3:0]  cfg_phase = '0;
  logic        busy, rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [7:0]  rom_ad_o, rom_ad_i;
  logic        rom_ad_oe, rom_ce_n, rom_hi_le, rom_mid_le;
  logic [1:0]  rom_a;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bootrom_rd_seq u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_sel(ctl_sel),
    .ctl_word(ctl_word), .ctl_addr(ctl_addr), .cfg_phase(cfg_phase),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rom_ad_o(rom_ad_o), .rom_ad_oe(rom_ad_oe), .rom_ad_i(rom_ad_i), .rom_a(rom_a),
    .rom_ce_n(rom_ce_n), .rom_hi_le(rom_hi_le), .rom_mid_le(rom_mid_le)
  );

  // external latches and ROM model
  logic [7:0] hi_q = '0, mid_q = '0;
  always @(posedge clk) begin
    if (rom_hi_le)  hi_q  <= rom_ad_o;
    if (rom_mid_le) mid_q <= rom_ad_o;
  end

  function automatic logic [7:0] romf(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {a[17:16], 6'h15} ^ 8'h3C;
  endfunction

  assign rom_ad_i = rom_ce_n ? 8'hEE : romf({hi_q, mid_q, rom_a});

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expect_data(input logic [17:0] a, input bit w);
    logic [31:0] r = '0;
    if (!w) r[7:0] = romf(a);
    else for (int i = 0; i < 4; i++) r[8*i +: 8] = romf({a[17:2], 2'(i)});
    return r;
  endfunction

  task automatic do_read(input logic [17:0] a, input bit w, input logic [3:0] ph,
                         input bit inject, input bit hold);
    int n = (ph == 0) ? 4 : int'(ph);
    int k = w ? 4 : 1;
    int c = 0;
    logic [31:0] exp_d = expect_data(a, w);
    if (hold) rsp_ready = 1'b0;
    ctl_wr = 1; ctl_rd = 1; ctl_sel = 1; ctl_word = w; ctl_addr = a; cfg_phase = ph;
    @(negedge clk);
    ctl_wr = 0; cfg_phase = 4'd7; ctl_addr = ~a; ctl_word = ~w;
    while (busy && c < 200) begin
      int p = c / n;
      logic [13:0] act, exp;
      act = {rom_ad_oe, rom_hi_le, rom_mid_le, rom_ce_n, rom_a, rom_ad_o};
      if (p == 0)      exp = {4'b1101, 2'b00, a[17:10]};
      else if (p == 1) exp = {4'b1011, 2'b00, a[9:2]};
      else             exp = {4'b0000, (w ? 2'(p - 2) : a[1:0]), 8'h00};
      // pin sequence: R4 high slice, R5 middle slice, R6/R7 data phases, R10
      chk(act == exp, "pins R4 R5 R6 R7 R10", 32'(act), 32'(exp));
      if (inject && c == 2) ctl_wr = 1;
      if (inject && c == 3) ctl_wr = 0;
      c++;
      @(negedge clk);
    end
    ctl_wr = 0;
    chk(c == (2 + k) * n, "R8 busy cycles", 32'(c), 32'((2 + k) * n));
    chk(rsp_valid == 1'b1, "R9 valid at busy fall", 32'(rsp_valid), 32'd1);
    chk(rsp_data == exp_d, w ? "R7 word data" : "R6 byte data", rsp_data, exp_d);
    if (inject) chk(rsp_data == exp_d, "R3 launch while busy ignored", rsp_data, exp_d);
    if (hold) begin
      for (int h = 0; h < 3; h++) begin
        if (h == 0) ctl_wr = 1;
        if (h == 1) ctl_wr = 0;
        @(negedge clk);
        chk(rsp_valid && rsp_data == exp_d, "R9 hold under back-pressure", rsp_data, exp_d);
      end
      chk(busy == 1'b0, "R3 launch while response pending ignored", 32'(busy), 32'd0);
      rsp_ready = 1'b1;
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 valid clears after accept", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] addrs [6];
    logic [3:0]  phs [5];
    int idx = 0;
    addrs = '{18'h00000, 18'h3FFFF, 18'h2A5C1, 18'h15A3E, 18'h0FF02, 18'h30013};
    phs   = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({busy, rsp_valid, rom_ce_n, rom_ad_oe, rom_hi_le, rom_mid_le} == 6'b001000,
        "R1 reset state", 32'({busy, rsp_valid, rom_ce_n, rom_ad_oe, rom_hi_le, rom_mid_le}), 32'b001000);
    chk({rom_ad_o, rom_a} == 10'd0, "R1 idle pins zero", 32'({rom_ad_o, rom_a}), 32'd0);
    // R2 partial control writes
    for (int m = 0; m < 3; m++) begin
      ctl_wr = 1; ctl_rd = (m != 0); ctl_sel = (m != 1); ctl_addr = 18'h12345;
      if (m == 2) ctl_wr = 0;
      @(negedge clk);
      ctl_wr = 0;
      repeat (4) @(negedge clk);
      chk(!busy && !rsp_valid && rom_ce_n, "R2 incomplete launch ignored",
          32'({busy, rsp_valid, rom_ce_n}), 32'b001);
    end
    // sweep phase lengths, modes and addresses
    foreach (phs[p]) begin
      for (int w = 0; w < 2; w++) begin
        foreach (addrs[i]) begin
          do_read(addrs[i], w[0], phs[p], (idx % 3) == 1, (idx % 2) == 1);
          idx++;
        end
      end
    end
    // every low-bit offset in byte mode
    for (int lo = 0; lo < 4; lo++) do_read({16'hB7C4, 2'(lo)}, 1'b0, 4'd2, 1'b0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule